// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is a synchronous binary down counter meant for divide-by-N work on a single system clock. A count input supplies the pulses to be divided; each rising edge of it lowers the count by one, and an inhibit input can both block those edges and act as a second pulse source on its falling edge while the count input rests high. A clear input zeroes the counter and a load input copies a preset value in. Both are level actions checked at every system clock edge, and clear outranks load, which outranks counting.

A decoded zero flag is raised while the count is all zeroes, but only while a chain-enable input is high. Several stages can then be chained with no extra gates, each stage's flag feeding the chain-enable of the next less significant stage. For a single stage, the zero flag is wired back to the load input. Every time the count reaches zero, the preset N is reloaded, so the flag pulses once per N count edges.

The count and inhibit inputs are sampled into the system clock domain and compared with their previous samples to find edges. At most one decrement happens in any system clock cycle.

Top module: `cascade_down_counter`

## Requirements
- R1: While `clear` is high at a system clock edge, the count becomes 0 after that edge, whatever the other inputs do.
- R2: While `clear` is low and `load_en` is high at a system clock edge, the count takes `load_val` after that edge (bit 0 is the least significant bit of both buses). A count edge that is detected in that cycle is discarded.
- R3: A low-to-high change of `cnt_in` while `inhibit` is low lowers the count by one. The change appears after the second system clock edge that follows the input change. Holding `cnt_in` at a steady level causes no change.
- R4: While `inhibit` is high, rising edges of `cnt_in` leave the count unchanged.
- R5: While `cnt_in` is high, a high-to-low change of `inhibit` lowers the count by one.
- R6: A decrement from 0 gives 15 (all ones).
- R7: `zero_flag` is high exactly when `chain_en` is high and the count is 0, including right after a clear. While `chain_en` is low, `zero_flag` stays low.
- R8: The count never moves down by more than one per system clock cycle. A rising `cnt_in` and a falling `inhibit` that are seen in the same cycle give a single decrement.
- R9: With `load_en` driven by `zero_flag` and `chain_en` high, `zero_flag` pulses once every N count edges, for every N from 1 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clear | input | 1 | Synchronous active-high clear of the count and of the edge samplers |
| cnt_in | input | 1 | Count pulse input, decrements on its rising edge |
| inhibit | input | 1 | Blocks count pulses when high; its falling edge counts while cnt_in is high |
| load_en | input | 1 | Loads load_val into the count when high |
| chain_en | input | 1 | Enables the zero flag |
| load_val | input | 4 | Preset value, bit 0 least significant |
| count | output | 4 | Current count, bit 0 least significant |
| zero_flag | output | 1 | High while chain_en is high and the count is 0 |

## Verification
A wrong count shows on `count` at the first sample after the edge that caused it, and in divide-by-N use it also moves the zero pulse by at least one input period. A lost or doubled decrement therefore shows within one count period. A wrong edge-sampler state shows as a decrement with no input edge, or as one that is missing. The bench catches both because it compares the count after every pulse against an arithmetic model, and it checks the exact latency of the first pulse. A faulty priority between clear, load and counting shows as a wrong count right after the cycle in which they overlap.

// File: rtl/dncnt_pkg.sv
package dncnt_pkg;

    // Edge events derived from one sampled input
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // What the count register does in a given cycle
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    // Priority: clear over load over step
    function automatic act_e pick_action(input logic clr, input logic ld, input logic stp);
        if (clr)      return ACT_CLEAR;
        else if (ld)  return ACT_LOAD;
        else if (stp) return ACT_STEP;
        else          return ACT_KEEP;
    endfunction

endpackage

// File: rtl/dncnt_edge_sampler.sv
module dncnt_edge_sampler
    import dncnt_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ev,
    output logic  level
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] pipe;
    logic              prev;

    // Sampling chain; on reset every stage follows the input so no edge
    // is reported when reset is released.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= din;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= din;
        else     prev <= pipe[LAST];
    end

    assign level   = pipe[LAST];
    assign ev.rise = pipe[LAST] & ~prev;
    assign ev.fall = ~pipe[LAST] & prev;

endmodule

// File: rtl/dncnt_step_gen.sv
module dncnt_step_gen
    import dncnt_pkg::*;
(
    input  edge_t cnt_ev,
    input  logic  cnt_lvl,
    input  edge_t inh_ev,
    input  logic  inh_lvl,
    output logic  step
);
    logic from_cnt;
    logic from_inh;

    // Count edge is honoured only with inhibit low; inhibit falling edge
    // counts only with the count input resting high. Either source gives
    // a single step.
    always_comb begin
        from_cnt = cnt_ev.rise & ~inh_lvl;
        from_inh = inh_ev.fall & cnt_lvl;
        step     = from_cnt | from_inh;
    end

endmodule

// File: rtl/dncnt_core.sv
module dncnt_core
    import dncnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    act_e         act;
    logic [W-1:0] nxt;

    always_comb begin
        act = pick_action(clear, load_en, step);
        unique case (act)
            ACT_CLEAR: nxt = ZERO;
            ACT_LOAD:  nxt = load_val;
            ACT_STEP:  nxt = count - ONE;   // wraps from zero to all ones
            default:   nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        count <= nxt;
    end

endmodule

// File: rtl/cascade_down_counter.sv
module cascade_down_counter
    import dncnt_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 1
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         cnt_in,
    input  logic         inhibit,
    input  logic         load_en,
    input  logic         chain_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         zero_flag
);
    edge_t cnt_ev;
    edge_t inh_ev;
    logic  cnt_lvl;
    logic  inh_lvl;
    logic  step;

    dncnt_edge_sampler #(.STAGES(SYNC_STAGES)) u_cnt_smp (
        .clk   (clk),
        .rst   (clear),
        .din   (cnt_in),
        .ev    (cnt_ev),
        .level (cnt_lvl)
    );

    dncnt_edge_sampler #(.STAGES(SYNC_STAGES)) u_inh_smp (
        .clk   (clk),
        .rst   (clear),
        .din   (inhibit),
        .ev    (inh_ev),
        .level (inh_lvl)
    );

    dncnt_step_gen u_step (
        .cnt_ev  (cnt_ev),
        .cnt_lvl (cnt_lvl),
        .inh_ev  (inh_ev),
        .inh_lvl (inh_lvl),
        .step    (step)
    );

    dncnt_core #(.W(W)) u_core (
        .clk      (clk),
        .clear    (clear),
        .load_en  (load_en),
        .load_val (load_val),
        .step     (step),
        .count    (count)
    );

    assign zero_flag = chain_en & (count == '0);

endmodule

// File: rtl/dncnt_checker.sv
module dncnt_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clear,
    input logic         inhibit,
    input logic         load_en,
    input logic         chain_en,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         zero_flag
);
    localparam logic [W-1:0] ALL1 = '1;

    // R1
    clear_zeroes_chk: assert property (@(posedge clk) clear |=> count == '0);

    // R2
    load_takes_val_chk: assert property (@(posedge clk) disable iff (clear)
        load_en |=> count == $past(load_val));

    // R4
    inhibit_blocks_chk: assert property (@(posedge clk) disable iff (clear)
        ($past(inhibit) && $past(inhibit, 2) && !$past(load_en) && !$past(clear))
        |-> count == $past(count));

    // R6
    wrap_to_max_chk: assert property (@(posedge clk) disable iff (clear)
        (!$past(clear) && !$past(load_en) && $past(count) == '0 && count != '0)
        |-> count == ALL1);

    // R8
    single_step_chk: assert property (@(posedge clk) disable iff (clear)
        (!$past(clear) && !$past(load_en))
        |-> (count == $past(count) || count == W'($past(count) - 1'b1)));

    // R7
    chain_gate_chk: assert property (@(posedge clk) !chain_en |-> !zero_flag);

endmodule

bind cascade_down_counter dncnt_checker #(.W(W)) u_dncnt_chk (
    .clk       (clk),
    .clear     (clear),
    .inhibit   (inhibit),
    .load_en   (load_en),
    .chain_en  (chain_en),
    .load_val  (load_val),
    .count     (count),
    .zero_flag (zero_flag)
);

// File: tb/test_cascade_down_counter.sv
module test_cascade_down_counter;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       cnt_in = 1'b0;
    logic       inhibit = 1'b0;
    logic       load_drv = 1'b0;
    logic       tie_load = 1'b0;
    logic       chain_en = 1'b1;
    logic [3:0] load_val = 4'd0;
    logic [3:0] count;
    logic       zero_flag;
    wire        load_en = tie_load ? zero_flag : load_drv;

    int total = 0;
    int bad   = 0;
    int zhits = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    cascade_down_counter i_cascade_down_counter (
        .clk       (clk),
        .clear     (clear),
        .cnt_in    (cnt_in),
        .inhibit   (inhibit),
        .load_en   (load_en),
        .chain_en  (chain_en),
        .load_val  (load_val),
        .count     (count),
        .zero_flag (zero_flag)
    );

    always @(negedge clk) if (zero_flag) zhits++;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full count pulse; model decrements when inhibit is low
    task automatic pulse;
        @(negedge clk) cnt_in = 1'b1;
        wait_n(3);
        if (!inhibit) exp_cnt = (exp_cnt + 15) % 16;
        cnt_in = 1'b0;
        wait_n(3);
    endtask

    task automatic do_clear(input logic [3:0] v);
        @(negedge clk);
        load_val = v;
        clear = 1'b1;
        wait_n(2);
        clear = 1'b0;
        exp_cnt = 0;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: clear overrides a pending load
        load_drv = 1'b1;
        load_val = 4'd9;
        wait_n(3);
        check(count == 4'd0, "R1 clear over load", count, 0);
        // R7: zero flag right after clear
        check(zero_flag == 1'b1, "R7 zero after clear", zero_flag, 1);
        clear = 1'b0;
        wait_n(1);
        // R2: load value, bit 0 LSB
        check(count == 4'd9, "R2 load", count, 9);
        load_val = 4'd1;
        wait_n(1);
        check(count == 4'd1, "R2 load lsb", count, 1);
        load_drv = 1'b0;
        exp_cnt = 1;

        // R3: exact latency of a count edge
        @(negedge clk) cnt_in = 1'b1;
        @(negedge clk);
        check(count == 4'd1, "R3 no change one edge after", count, 1);
        @(negedge clk);
        check(count == 4'd0, "R3 decrement two edges after", count, 0);
        wait_n(6);
        check(count == 4'd0, "R3 steady high no step", count, 0);
        cnt_in = 1'b0;
        wait_n(3);
        exp_cnt = 0;

        // R6: wrap 0 -> 15
        pulse();
        check(count == 4'd15, "R6 wrap", count, 15);
        for (int k = 0; k < 5; k++) begin
            pulse();
            check(count == 4'(exp_cnt), "R3 sweep", count, exp_cnt);
        end

        // R4: inhibit blocks count edges
        @(negedge clk) inhibit = 1'b1;
        wait_n(2);
        pulse();
        pulse();
        check(count == 4'(exp_cnt), "R4 inhibit blocks", count, exp_cnt);

        // R5: inhibit falling edge counts while cnt_in high, across wrap
        @(negedge clk) cnt_in = 1'b1;
        wait_n(3);
        check(count == 4'(exp_cnt), "R4 rise under inhibit", count, exp_cnt);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk) inhibit = 1'b0;
            wait_n(3);
            exp_cnt = (exp_cnt + 15) % 16;
            check(count == 4'(exp_cnt), "R5 inhibit clocked", count, exp_cnt);
            @(negedge clk) inhibit = 1'b1;
            wait_n(3);
            check(count == 4'(exp_cnt), "R5 inhibit rise no step", count, exp_cnt);
        end
        @(negedge clk) cnt_in = 1'b0;
        wait_n(3);

        // R8: rising cnt_in and falling inhibit in the same cycle
        @(negedge clk) begin cnt_in = 1'b1; inhibit = 1'b0; end
        wait_n(4);
        exp_cnt = (exp_cnt + 15) % 16;
        check(count == 4'(exp_cnt), "R8 single step", count, exp_cnt);
        @(negedge clk) cnt_in = 1'b0;
        wait_n(3);

        // R2: load wins over a coincident count edge
        @(negedge clk) begin load_val = 4'd10; load_drv = 1'b1; cnt_in = 1'b1; end
        wait_n(4);
        load_drv = 1'b0;
        wait_n(3);
        check(count == 4'd10, "R2 load over step", count, 10);
        cnt_in = 1'b0;
        wait_n(3);
        exp_cnt = 10;

        // R7: chain gate
        do_clear(4'd0);
        chain_en = 1'b0;
        wait_n(1);
        check(zero_flag == 1'b0, "R7 chain low", zero_flag, 0);
        chain_en = 1'b1;
        wait_n(1);
        check(zero_flag == 1'b1, "R7 chain high", zero_flag, 1);
        pulse();
        check(zero_flag == 1'b0, "R7 nonzero", zero_flag, 0);

        // R9: divide-by-N for every N
        for (int n = 1; n <= 15; n++) begin
            tie_load = 1'b1;
            do_clear(4'(n));
            wait_n(2);
            check(count == 4'(n), "R9 reload after clear", count, n);
            zhits = 0;
            for (int p = 0; p < 2 * n; p++) pulse();
            check(zhits == 2, "R9 pulses per 2N", zhits, 2);
            check(count == 4'(n), "R9 reloaded N", count, n);
        end
        tie_load = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule